// File: doc/BRIEF.md
# Calendar Event Interrupt Unit

This unit sits beside a calendar counter chain and turns its activity into two sticky interrupt flags. It takes eight time fields: second, minute, hour, day of month, day of week, day of year, month and year. Each field arrives with a one-cycle strobe that pulses when the counter chain advances that field. The unit also takes a matching set of alarm values and an alarm mask. Software writes a small clear register to acknowledge the flags. The single interrupt output is the OR of the two flags.

The tick flag is set when a strobe arrives on any field whose bit is 1 in the tick-enable vector. The alarm flag is set on the clock edge where the compare condition first becomes true. The compare condition requires every field whose mask bit is 0 to equal its alarm value. A condition that stays true does not set the flag a second time. When all eight mask bits are 1, the alarm is switched off.

The unit has no streaming data path. Every pin is a plain level or a one-cycle strobe. There is therefore no valid/ready handshake and no back-pressure. A clear write is taken in the cycle where `clr_we` is high and is never stalled.

Top module: `rtc_evt_irq`

## Requirements
- R1: Bit k of `tick_en` and of `field_stb` belongs to field k. Field 0 is second, then minute, hour, day of month, day of week, day of year, month, and field 7 is year. Field k of `time_vec` and of `alarm_vec` sits at bits [k*FIELD_W +: FIELD_W].
- R2: A cycle with `field_stb[k]` and `tick_en[k]` both 1 sets `tick_flag` at the next clock edge. A strobe on a field whose enable bit is 0 leaves `tick_flag` at 0.
- R3: `tick_flag` stays at 1 until a cycle with `clr_we`=1 and `clr_data[0]`=1. It reads 0 after that edge.
- R4: The compare condition holds when every field whose `alarm_mask` bit is 0 equals its `alarm_vec` field. A difference in a masked field does not affect the condition.
- R5: `alarm_flag` is set only at an edge where the compare condition is true and it was false at the previous edge. A condition that persists does not set the flag again after it has been cleared.
- R6: A cycle with `clr_we`=1 and `clr_data[1]`=1 clears `alarm_flag` at the next edge.
- R7: When `alarm_mask` is all ones, the compare condition is false and `alarm_flag` is never set.
- R8: A clear write with a 0 in a bit of `clr_data` leaves the matching flag unchanged.
- R9: If a set event and a clear write for the same flag fall in the same cycle, the flag is 1 after that edge.
- R10: `irq` is 1 exactly when at least one flag is 1. Reset clears both flags and the stored previous compare state, so a match seen at the first edge after reset counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_vec | input | NUM_FIELDS*FIELD_W | Current field values, field k at [k*FIELD_W +: FIELD_W] |
| field_stb | input | NUM_FIELDS | One-cycle advance strobe per field |
| tick_en | input | NUM_FIELDS | Per-field tick interrupt enable |
| alarm_vec | input | NUM_FIELDS*FIELD_W | Alarm compare values, same layout as time_vec |
| alarm_mask | input | NUM_FIELDS | 1 excludes a field from the compare |
| clr_we | input | 1 | Clear register write strobe |
| clr_data | input | 2 | Bit 0 clears the tick flag, bit 1 clears the alarm flag |
| tick_flag | output | 1 | Sticky tick interrupt flag |
| alarm_flag | output | 1 | Sticky alarm interrupt flag |
| irq | output | 1 | OR of the two flags |

## Verification
The bench runs every tick-enable value against a strobe on each single field. A swapped bit order or an ungated strobe would set the tick flag for the wrong field. It also runs every mask value against a mismatch placed in each single field. A design that ignored the mask, or let the all-ones mask act as "match everything", would fire where it must not. The bench clears the alarm flag while the match persists to catch a level-triggered alarm, which would fire again at once. It applies set and clear in the same cycle to catch clear-wins priority. It writes clear values with zero bits to catch a design that clears both flags on any write.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
  localparam int CLR_W       = 2;
  localparam int CLR_TICK_B  = 0;
  localparam int CLR_ALARM_B = 1;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_DOM  = 3'd3,
    FLD_DOW  = 3'd4,
    FLD_DOY  = 3'd5,
    FLD_MON  = 3'd6,
    FLD_YEAR = 3'd7
  } field_idx_e;
endpackage

// File: rtl/rtc_tick_detect.sv
module rtc_tick_detect #(
  parameter int NUM_FIELDS = 8
) (
  input  logic [NUM_FIELDS-1:0] field_stb,
  input  logic [NUM_FIELDS-1:0] tick_en,
  output logic                  tick_evt
);
  logic [NUM_FIELDS-1:0] gated;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_gate
    assign gated[k] = field_stb[k] & tick_en[k];
  end

  assign tick_evt = |gated;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_FIELDS*FIELD_W-1:0] time_vec,
  input  logic [NUM_FIELDS*FIELD_W-1:0] alarm_vec,
  input  logic [NUM_FIELDS-1:0]         alarm_mask,
  output logic                          alarm_rise
);
  logic [NUM_FIELDS-1:0] fld_ok;
  logic                  all_masked;
  logic                  match_now;
  logic                  match_prev_q;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_cmp
    assign fld_ok[k] = alarm_mask[k] |
                       (time_vec[k*FIELD_W +: FIELD_W] == alarm_vec[k*FIELD_W +: FIELD_W]);
  end

  assign all_masked = &alarm_mask;
  assign match_now  = (&fld_ok) & ~all_masked;

  always_ff @(posedge clk) begin
    if (!rst_n) match_prev_q <= 1'b0;
    else        match_prev_q <= match_now;
  end

  assign alarm_rise = match_now & ~match_prev_q;

  // R5: a held match never produces a second rise
  a_r5_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    match_prev_q |-> !alarm_rise);

  // R7: fully masked compare never rises
  a_r7_all_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    (&alarm_mask) |-> !alarm_rise);
endmodule

// File: rtl/rtc_sticky_flag.sv
module rtc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  // R9: set has priority over a simultaneous clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  // R8: no set and no clear keeps the flag
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/rtc_evt_irq.sv
module rtc_evt_irq
  import rtc_evt_pkg::*;
#(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_FIELDS*FIELD_W-1:0] time_vec,
  input  logic [NUM_FIELDS-1:0]         field_stb,
  input  logic [NUM_FIELDS-1:0]         tick_en,
  input  logic [NUM_FIELDS*FIELD_W-1:0] alarm_vec,
  input  logic [NUM_FIELDS-1:0]         alarm_mask,
  input  logic                          clr_we,
  input  logic [CLR_W-1:0]              clr_data,
  output logic                          tick_flag,
  output logic                          alarm_flag,
  output logic                          irq
);
  localparam int NFLAGS = CLR_W;

  logic              tick_evt;
  logic              alarm_rise;
  logic [NFLAGS-1:0] set_vec;
  logic [NFLAGS-1:0] clr_vec;
  logic [NFLAGS-1:0] flag_vec;

  rtc_tick_detect #(.NUM_FIELDS(NUM_FIELDS)) u_tick (
    .field_stb (field_stb),
    .tick_en   (tick_en),
    .tick_evt  (tick_evt)
  );

  rtc_alarm_cmp #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_alarm (
    .clk        (clk),
    .rst_n      (rst_n),
    .time_vec   (time_vec),
    .alarm_vec  (alarm_vec),
    .alarm_mask (alarm_mask),
    .alarm_rise (alarm_rise)
  );

  assign set_vec[CLR_TICK_B]  = tick_evt;
  assign set_vec[CLR_ALARM_B] = alarm_rise;

  for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
    assign clr_vec[f] = clr_we & clr_data[f];
    rtc_sticky_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[f]),
      .clr_i  (clr_vec[f]),
      .flag_q (flag_vec[f])
    );
  end

  assign tick_flag  = flag_vec[CLR_TICK_B];
  assign alarm_flag = flag_vec[CLR_ALARM_B];
  assign irq        = |flag_vec;

  // R2: an enabled strobe reaches the tick flag one edge later
  a_r2_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
    |(field_stb & tick_en) |=> tick_flag);

  // R3: tick flag falls only after a clear write with bit 0 set
  a_r3_tick_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_flag && !(clr_we && clr_data[CLR_TICK_B])) |=> tick_flag);

  // R6: alarm clear without a new rise drops the flag
  a_r6_alarm_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_data[CLR_ALARM_B] && !alarm_rise) |=> !alarm_flag);

  // R10: a new alarm flag needs the mask not fully set
  a_r10_alarm_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> !$past(&alarm_mask));
endmodule

// File: tb/rtc_evt_irq_tb_top.sv
module rtc_evt_irq_tb_top;
  localparam int NF = 8;
  localparam int FW = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NF*FW-1:0] time_vec = '0;
  logic [NF-1:0]   field_stb = '0;
  logic [NF-1:0]   tick_en = '0;
  logic [NF*FW-1:0] alarm_vec = '0;
  logic [NF-1:0]   alarm_mask = '1;
  logic            clr_we = 1'b0;
  logic [1:0]      clr_data = '0;
  logic            tick_flag, alarm_flag, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_evt_irq #(.NUM_FIELDS(NF), .FIELD_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .time_vec(time_vec), .field_stb(field_stb),
    .tick_en(tick_en), .alarm_vec(alarm_vec), .alarm_mask(alarm_mask),
    .clr_we(clr_we), .clr_data(clr_data), .tick_flag(tick_flag),
    .alarm_flag(alarm_flag), .irq(irq)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // base time: field k holds 3*k+5; alarm differs from time in every field
  function automatic logic [NF*FW-1:0] base_time();
    logic [NF*FW-1:0] v;
    for (int k = 0; k < NF; k++) v[k*FW +: FW] = FW'(3*k + 5);
    return v;
  endfunction

  task automatic clear_all();
    clr_we = 1'b1; clr_data = 2'b11;
    step();
    clr_we = 1'b0; clr_data = 2'b00;
  endtask

  initial begin
    step(); step();
    // R10: reset state
    chk(tick_flag, 1'b0, "R10 reset tick");
    chk(alarm_flag, 1'b0, "R10 reset alarm");
    chk(irq, 1'b0, "R10 reset irq");
    rst_n = 1'b1;
    time_vec = base_time();
    alarm_vec = base_time() ^ {NF{12'h001}};
    step();

    // R1 R2 R3 R8 R10: every enable value against each single-field strobe
    for (int en = 0; en < 256; en++) begin
      for (int f = 0; f < NF; f++) begin
        logic e;
        e = en[f];
        tick_en = NF'(en);
        field_stb = NF'(1) << f;
        step();
        field_stb = '0;
        chk(tick_flag, e, "R1/R2 tick set by enabled field");
        chk(irq, e, "R10 irq follows tick");
        clr_we = 1'b1; clr_data = 2'b10;
        step();
        chk(tick_flag, e, "R8/R3 zero bit keeps tick");
        clr_data = 2'b01;
        step();
        clr_we = 1'b0; clr_data = 2'b00;
        chk(tick_flag, 1'b0, "R3 tick cleared");
      end
    end
    tick_en = '0;

    // R4 R5 R6 R7: every mask against a mismatch in each single field
    for (int m = 0; m < 256; m++) begin
      for (int f = 0; f < NF; f++) begin
        logic e;
        e = m[f] && (m != 255);
        alarm_mask = NF'(m);
        alarm_vec = base_time() ^ {NF{12'h001}};
        step();
        chk(alarm_flag, 1'b0, "R4 no match when all fields differ");
        alarm_vec = base_time();
        alarm_vec[f*FW +: FW] = alarm_vec[f*FW +: FW] ^ 12'h800;
        step();
        chk(alarm_flag, e, (m == 255) ? "R7 all masked stays off" : "R4 masked compare");
        chk(irq, e, "R10 irq follows alarm");
        clr_we = 1'b1; clr_data = 2'b01;
        step();
        chk(alarm_flag, e, "R8 zero bit keeps alarm");
        clr_data = 2'b10;
        step();
        clr_we = 1'b0; clr_data = 2'b00;
        chk(alarm_flag, 1'b0, "R6 alarm cleared");
        step();
        chk(alarm_flag, 1'b0, "R5 held match does not refire");
      end
    end

    // R7: fully masked with every field equal
    alarm_mask = '1;
    alarm_vec = base_time();
    step(); step();
    chk(alarm_flag, 1'b0, "R7 all masked equal fields");

    // R9: set and clear in the same cycle, tick
    tick_en = '1;
    field_stb = 8'h04;
    clr_we = 1'b1; clr_data = 2'b01;
    step();
    field_stb = '0; clr_we = 1'b0; clr_data = '0;
    chk(tick_flag, 1'b1, "R9 tick set wins");
    clear_all();
    tick_en = '0;

    // R9: set and clear in the same cycle, alarm
    alarm_mask = '0;
    alarm_vec = base_time() ^ {NF{12'h001}};
    step();
    alarm_vec = base_time();
    clr_we = 1'b1; clr_data = 2'b10;
    step();
    clr_we = 1'b0; clr_data = '0;
    chk(alarm_flag, 1'b1, "R9 alarm set wins");

    // R10: reset clears flags and previous match state
    tick_en = '1; field_stb = 8'h80;
    step();
    field_stb = '0;
    rst_n = 1'b0;
    step();
    chk(tick_flag, 1'b0, "R10 reset clears tick");
    chk(alarm_flag, 1'b0, "R10 reset clears alarm");
    chk(irq, 1'b0, "R10 reset clears irq");
    rst_n = 1'b1;
    step();
    chk(alarm_flag, 1'b1, "R10 match after reset is a rise");
    clear_all();
    step();
    chk(alarm_flag, 1'b0, "R5 no refire after reset rise");

    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule